// File: doc/BRIEF.md
# Attribute-Controlled Configuration Register Bank

This block holds a small set of 32-bit configuration and status registers behind a simple request/acknowledge configuration port. An access carries a function number, a dword address, four byte enables, a write flag and write data. Every access, whether it lands on an implemented register, a reserved location, or an unused function, is acknowledged exactly one cycle later. There is no wait state and no way for the port to stall.

Each bit has its own access attribute. Read-only bits hold a fixed value. Read/write bits take write data. Status bits are cleared by writing one and are set by hardware event inputs. Sticky bits are also set by events and cleared by writing one, but they keep their value through a hard reset. Two asynchronous active-low reset inputs are each released through a synchronizer. The hard reset restores every non-sticky bit to its default. The power-on reset restores everything, including the sticky bits.

Function 0 implements dword addresses 0 to 3 with these layouts:
- Register 0: bits [15:0] read/write; bits [23:16] read-only with value 0xA5; bits [31:24] reserved.
- Register 1: bits [7:0] status (write-one-to-clear); bits [15:8] sticky; bits [31:16] read/write.
- Register 2: all 32 bits read/write.
- Register 3: bits [7:0] read/write; bits [15:8] sticky; bits [31:16] reserved.

Top module: `cfgreg_bank`

## Requirements
- R1: After either reset the registers read 0x00A5_0000, 0x0000_0000, 0x1234_5678 and 0x0000_00FF at dword addresses 0 to 3 of function 0.
- R2: Read-only and reserved bits are unchanged by writes. Register 0 bits [23:16] always read 0xA5, and reserved bits always read 0.
- R3: Read/write bits with an enabled byte lane take the write data, and the new value is visible to the next access.
- R4: Writing 1 to a status or sticky bit clears it and writing 0 leaves it unchanged. A 1 on that bit's event input (event bit 32*r+b for register r, bit b) sets it. Events on any other bit have no effect.
- R5: When an event and a write-one clear hit the same bit in the same cycle, the bit ends set.
- R6: Sticky bits (register 1 and register 3, bits [15:8]) keep their value through a hard reset, while all other bits return to their defaults.
- R7: The power-on reset returns every bit, sticky bits included, to the defaults of R1.
- R8: Byte enable k qualifies bits [8k+7:8k]. A disabled lane leaves every bit in it unchanged, whatever its attribute.
- R9: An access to function number other than 0, or to a dword address above 3, is acknowledged, reads 0, and changes no register.
- R10: `ack` is high in exactly the cycle after each request cycle, with `rdata` valid alongside it. A read returns the value held before that cycle's update. `rdata` is 0 for writes and when `ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| req | input | 1 | Access request, one cycle per access |
| func | input | FUNC_W (3) | Function number |
| addr | input | ADDR_W (6) | Dword address |
| wr | input | 1 | 1 = write, 0 = read |
| be | input | 4 | Byte enables |
| wdata | input | 32 | Write data |
| ev_set | input | NUM_REGS*32 (128) | Hardware event set pulses, one per register bit |
| ack | output | 1 | Access completion |
| rdata | output | 32 | Read data |

## Verification
Acknowledge and read data are registered, so both are due at the first clock edge after the request. The bench drives each request on a falling edge and samples the outputs on the next falling edge. Write and event effects land on the same edge, so the bench checks them with the next access rather than the current one. Reset releases pass through two synchronizer stages, so the bench waits three rising edges after each release before it makes the next access. During the reset itself the bench checks that `ack` stays low.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

  localparam int DW    = 32;
  localparam int LANES = DW / 8;

  // Bit layout repeats every four registers.
  function automatic logic [DW-1:0] rw_mask(input int r);
    case (r % 4)
      0:       rw_mask = 32'h0000_FFFF;
      1:       rw_mask = 32'hFFFF_0000;
      2:       rw_mask = 32'hFFFF_FFFF;
      default: rw_mask = 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [DW-1:0] clr_mask(input int r);
    clr_mask = ((r % 4) == 1) ? 32'h0000_00FF : 32'h0;
  endfunction

  function automatic logic [DW-1:0] stk_mask(input int r);
    stk_mask = ((r % 4) == 1 || (r % 4) == 3) ? 32'h0000_FF00 : 32'h0;
  endfunction

  function automatic logic [DW-1:0] dflt_val(input int r);
    case (r % 4)
      0:       dflt_val = 32'h00A5_0000;
      2:       dflt_val = 32'h1234_5678;
      3:       dflt_val = 32'h0000_00FF;
      default: dflt_val = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/cfgreg_rst_sync.sv
module cfgreg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/cfgreg_word.sv
module cfgreg_word
  import cfgreg_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          hrst_n,
  input  logic          prst_n,
  input  logic          wr_en,
  input  logic [LANES-1:0] be,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ev,
  output logic [DW-1:0] val
);
  localparam logic [DW-1:0] RW   = rw_mask(IDX);
  localparam logic [DW-1:0] RC   = clr_mask(IDX);
  localparam logic [DW-1:0] ST   = stk_mask(IDX);
  localparam logic [DW-1:0] DEF  = dflt_val(IDX);
  localparam logic [DW-1:0] MAIN = RW | RC;
  localparam logic [DW-1:0] FIX  = ~(RW | RC | ST);

  logic [DW-1:0] q_main, q_stk, d_main, d_stk;
  logic [DW-1:0] lane_m, wsel, wone;
  logic          en_main, en_stk;

  always_comb begin
    for (int k = 0; k < LANES; k++) lane_m[8*k +: 8] = {8{be[k]}};
    wsel    = wr_en ? lane_m : '0;
    wone    = wsel & wdata;
    d_main  = (((q_main & ~wsel) | wone) & RW) | (((q_main & ~wone) | ev) & RC);
    d_stk   = ((q_stk & ~wone) | ev) & ST;
    en_main = wr_en | (|(ev & RC));
    en_stk  = wr_en | (|(ev & ST));
  end

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n)      q_main <= DEF & MAIN;
    else if (en_main) q_main <= d_main;
  end

  always_ff @(posedge clk or negedge prst_n) begin
    if (!prst_n)     q_stk <= '0;
    else if (en_stk) q_stk <= d_stk;
  end

  assign val = (q_main & MAIN) | (q_stk & ST) | (DEF & FIX);

  // R5 / R4: an event-set bit reads back as 1 after the edge, clear or not
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!hrst_n || !prst_n)
    (|(ev & (RC | ST))) |=> ((val & $past(ev & (RC | ST))) == $past(ev & (RC | ST))));

  // R8: a disabled lane keeps its read/write bits
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    a_r8_lane_hold: assert property (@(posedge clk) disable iff (!hrst_n || !prst_n)
      (wr_en && !be[k]) |=> $stable(val[8*k +: 8] & RW[8*k +: 8]));
  end
endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
  import cfgreg_pkg::*;
#(
  parameter int FUNC_W   = 3,
  parameter int ADDR_W   = 6,
  parameter int NUM_REGS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   por_n,
  input  logic                   req,
  input  logic [FUNC_W-1:0]      func,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr,
  input  logic [3:0]             be,
  input  logic [31:0]            wdata,
  input  logic [NUM_REGS*32-1:0] ev_set,
  output logic                   ack,
  output logic [31:0]            rdata
);
  logic hrst_n, prst_n, hard_in_n;
  logic [NUM_REGS-1:0][DW-1:0] vals;
  logic [NUM_REGS-1:0]         wr_hit;
  logic                        hit;
  logic [DW-1:0]               rd_sel, rdata_d;
  logic                        ack_q;
  logic [DW-1:0]               rdata_q;

  assign hard_in_n = rst_n & por_n;

  cfgreg_rst_sync u_hsync (.clk(clk), .arst_n(hard_in_n), .srst_n(hrst_n));
  cfgreg_rst_sync u_psync (.clk(clk), .arst_n(por_n),     .srst_n(prst_n));

  always_comb begin
    hit    = 1'b0;
    rd_sel = '0;
    wr_hit = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (func == '0 && addr == ADDR_W'(r)) begin
        hit       = 1'b1;
        rd_sel    = vals[r];
        wr_hit[r] = req & wr;
      end
    end
    rdata_d = (req && !wr && hit) ? rd_sel : '0;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    cfgreg_word #(.IDX(r)) u_word (
      .clk   (clk),
      .hrst_n(hrst_n),
      .prst_n(prst_n),
      .wr_en (wr_hit[r]),
      .be    (be),
      .wdata (wdata),
      .ev    (ev_set[r*DW +: DW]),
      .val   (vals[r])
    );
  end

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q   <= req;
      rdata_q <= rdata_d;
    end
  end

  assign ack   = ack_q;
  assign rdata = rdata_q;

  a_r10_ack_follows: assert property (@(posedge clk) disable iff (!hrst_n)
    req |=> ack);
  a_r10_ack_idle: assert property (@(posedge clk) disable iff (!hrst_n)
    !req |=> (!ack && rdata == '0));
  a_r9_undecoded_zero: assert property (@(posedge clk) disable iff (!hrst_n)
    (req && (func != '0 || addr >= ADDR_W'(NUM_REGS))) |=> (ack && rdata == '0));
endmodule

// File: tb/cfgreg_bank_test.sv
module cfgreg_bank_test;
  localparam int NR = 4;

  logic clk = 1'b0;
  logic rst_n, por_n, req, wr;
  logic [2:0] func;
  logic [5:0] addr;
  logic [3:0] be;
  logic [31:0] wdata;
  logic [NR*32-1:0] ev_set;
  logic ack;
  logic [31:0] rdata;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [31:0] m [NR];
  logic [31:0] last_rd;

  always #10 clk = ~clk;

  cfgreg_bank uut (.clk(clk), .rst_n(rst_n), .por_n(por_n), .req(req), .func(func),
    .addr(addr), .wr(wr), .be(be), .wdata(wdata), .ev_set(ev_set), .ack(ack), .rdata(rdata));

  function automatic logic [31:0] b_rw(int r);
    case (r) 0: return 32'h0000_FFFF; 1: return 32'hFFFF_0000;
      2: return 32'hFFFF_FFFF; default: return 32'h0000_00FF; endcase
  endfunction
  function automatic logic [31:0] b_set(int r);
    case (r) 1: return 32'h0000_FFFF; 3: return 32'h0000_FF00; default: return 32'h0; endcase
  endfunction
  function automatic logic [31:0] b_stk(int r);
    return (r == 1 || r == 3) ? 32'h0000_FF00 : 32'h0;
  endfunction
  function automatic logic [31:0] b_def(int r);
    case (r) 0: return 32'h00A5_0000; 2: return 32'h1234_5678;
      3: return 32'h0000_00FF; default: return 32'h0; endcase
  endfunction

  function automatic logic [31:0] b_next(int r, logic [31:0] cur, logic w, logic [3:0] b,
                                         logic [31:0] d, logic [31:0] e);
    logic [31:0] lm;
    for (int k = 0; k < 4; k++) lm[8*k +: 8] = (w && b[k]) ? 8'hFF : 8'h00;
    return ((((cur & ~lm) | (d & lm)) & b_rw(r)) |
            (((cur & ~(lm & d)) | e) & b_set(r)) |
            (b_def(r) & ~(b_rw(r) | b_set(r))));
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // One access: drive at a falling edge, check at the next falling edge.
  task automatic acc(string tag, logic [2:0] f, logic [5:0] a, logic w, logic [3:0] b,
                     logic [31:0] d, logic [NR*32-1:0] e);
    logic [31:0] exp_rd;
    logic [31:0] nx [NR];
    bit h;
    h = (f == 0) && (a < NR);
    exp_rd = (h && !w) ? m[a[1:0]] : 32'h0;
    for (int r = 0; r < NR; r++)
      nx[r] = b_next(r, m[r], w && h && (a == r), b, d, e[r*32 +: 32]);
    req = 1'b1; func = f; addr = a; wr = w; be = b; wdata = d; ev_set = e;
    @(negedge clk);
    check({tag, " R10 ack"}, {31'h0, ack}, 32'h1);
    check({tag, " R10 rdata"}, rdata, exp_rd);
    last_rd = rdata;
    for (int r = 0; r < NR; r++) m[r] = nx[r];
    req = 1'b0; wr = 1'b0; ev_set = '0;
  endtask

  task automatic rd(string tag, int a, logic [31:0] exp);
    acc(tag, 3'd0, 6'(a), 1'b0, 4'h0, 32'h0, '0);
    check(tag, last_rd, exp);
  endtask

  task automatic wr_reg(string tag, int a, logic [3:0] b, logic [31:0] d);
    acc(tag, 3'd0, 6'(a), 1'b1, b, d, '0);
  endtask

  task automatic hard_reset(bit power);
    if (power) por_n = 1'b0; else rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 ack low in reset", {31'h0, ack}, 32'h0);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int r = 0; r < NR; r++)
      m[r] = power ? b_def(r) : ((m[r] & b_stk(r)) | (b_def(r) & ~b_stk(r)));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; por_n = 1'b0; req = 1'b0; wr = 1'b0; func = '0; addr = '0;
    be = '0; wdata = '0; ev_set = '0;
    repeat (3) @(negedge clk);
    check("R10 ack low in reset", {31'h0, ack}, 32'h0);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int r = 0; r < NR; r++) m[r] = b_def(r);

    // R1 defaults
    rd("R1 reg0", 0, 32'h00A5_0000);
    rd("R1 reg1", 1, 32'h0000_0000);
    rd("R1 reg2", 2, 32'h1234_5678);
    rd("R1 reg3", 3, 32'h0000_00FF);
    // R2 read-only and reserved bits
    wr_reg("R2", 0, 4'hF, 32'hFFFF_FFFF);
    rd("R2 reg0", 0, 32'h00A5_FFFF);
    wr_reg("R2", 3, 4'hF, 32'hFFFF_00FF);
    rd("R2 reg3 reserved", 3, 32'h0000_00FF);
    // R3 read/write
    wr_reg("R3", 2, 4'hF, 32'hDEAD_BEEF);
    rd("R3 reg2", 2, 32'hDEAD_BEEF);
    // R4 set by event, write-one-to-clear, ignore events on RW bits
    acc("R4 ev", 3'd0, 6'd9, 1'b0, 4'h0, 32'h0, {32'h0, 32'h0, 32'h0000_000F, 32'hFFFF_FFFF});
    rd("R4 set", 1, 32'h0000_000F);
    rd("R4 ev ignored on reg0", 0, 32'h00A5_FFFF);
    wr_reg("R4", 1, 4'h1, 32'h0000_0005);
    rd("R4 w1c", 1, 32'h0000_000A);
    wr_reg("R4", 1, 4'h1, 32'h0000_0000);
    rd("R4 w0 keep", 1, 32'h0000_000A);
    // R5 event wins over clear
    acc("R5", 3'd0, 6'd1, 1'b1, 4'h1, 32'h0000_000A, {32'h0, 32'h0, 32'h0000_0002, 32'h0});
    rd("R5 set kept", 1, 32'h0000_0002);
    // R6 sticky through hard reset
    acc("R6 ev", 3'd0, 6'd1, 1'b1, 4'hC, 32'h5A5A_0000,
        {32'h0000_3C00, 32'h0, 32'h0000_AB00, 32'h0});
    rd("R6 pre", 1, 32'h5A5A_AB02);
    hard_reset(1'b0);
    rd("R6 reg1", 1, 32'h0000_AB00);
    rd("R6 reg3", 3, 32'h0000_3CFF);
    rd("R6 reg2", 2, 32'h1234_5678);
    wr_reg("R6 sticky w1c", 1, 4'h2, 32'h0000_0300);
    rd("R6 sticky w1c", 1, 32'h0000_A800);
    // R7 power-on reset
    hard_reset(1'b1);
    rd("R7 reg1", 1, 32'h0);
    rd("R7 reg3", 3, 32'h0000_00FF);
    // R8 byte lanes
    wr_reg("R8", 2, 4'b0100, 32'hFFFF_FFFF);
    rd("R8 lane2", 2, 32'h12FF_5678);
    acc("R8 ev", 3'd0, 6'd9, 1'b0, 4'h0, 32'h0, {32'h0, 32'h0, 32'h0000_FF0F, 32'h0});
    wr_reg("R8 w1c off lane", 1, 4'b1110, 32'hFFFF_FFFF);
    rd("R8 status lane held", 1, 32'hFFFF_000F);
    // R9 undecoded
    acc("R9 func1 wr", 3'd1, 6'd0, 1'b1, 4'hF, 32'h0000_1111, '0);
    acc("R9 func1 rd", 3'd1, 6'd2, 1'b0, 4'h0, 32'h0, '0);
    check("R9 func1 zero", last_rd, 32'h0);
    acc("R9 addr wr", 3'd0, 6'd40, 1'b1, 4'hF, 32'h0000_2222, '0);
    acc("R9 addr rd", 3'd0, 6'd9, 1'b0, 4'h0, 32'h0, '0);
    check("R9 addr zero", last_rd, 32'h0);
    rd("R9 reg0 untouched", 0, 32'h00A5_0000);
    // R10 idle cycle and write read-data
    @(negedge clk);
    check("R10 idle ack", {31'h0, ack}, 32'h0);
    wr_reg("R10 write rdata", 2, 4'hF, 32'h0BAD_F00D);
    check("R10 write rdata zero", last_rd, 32'h0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] f;
      logic [5:0] a;
      logic [NR*32-1:0] e;
      f = ($urandom % 6 == 0) ? 3'(1 + $urandom % 7) : 3'd0;
      a = ($urandom % 6 == 0) ? 6'($urandom) : 6'($urandom % NR);
      e = '0;
      if ($urandom % 3 == 0)
        for (int r = 0; r < NR; r++) e[r*32 +: 32] = $urandom & $urandom & $urandom;
      if ($urandom % 5 == 0) begin
        ev_set = e;
        @(negedge clk);
        check("R10 idle ack", {31'h0, ack}, 32'h0);
        for (int r = 0; r < NR; r++)
          m[r] = b_next(r, m[r], 1'b0, 4'h0, 32'h0, e[r*32 +: 32]);
        ev_set = '0;
      end else
        acc("R3/R4/R8 random", f, a, 1'($urandom), 4'($urandom), $urandom, e);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule